// File: doc/BRIEF.md
# Video Controller CPU Register Bank

This block sits between the host CPU bus and a tile-based video controller. Each access carries an address, a data byte and a read or write strobe. The bank decodes it into one of eight registers:

- control
- mask
- status
- sprite-memory address
- sprite-memory data
- scroll
- video-memory address
- video-memory data

The bank answers anywhere in the 8 KiB window from 0x2000 to 0x3FFF. Only the three low address bits choose the register, so the eight registers repeat every eight bytes.

From the control register the bank derives the configuration that the renderer uses:

- the base nametable address
- the background and sprite pattern table bases
- the sprite height
- the step of the video-memory pointer

The bank raises an active-low vertical-blank interrupt. It keeps the 14-bit video-memory pointer, which advances on every data-port access. Scroll and pointer loads take two writes each, tracked by a two-state write-phase machine. That machine has states `PH_FIRST` and `PH_SECOND`. A write to the scroll or address port moves it from `PH_FIRST` to `PH_SECOND` and back again. A status read forces it to `PH_FIRST` from either state.

The vertical-blank flag follows a set pulse and a clear pulse from the timing logic. It is also cleared when the CPU reads the status register. The sprite-0 and overflow flags are levels driven by the timing logic, and the bank passes them straight through to the status register.

Top module: `vid_cpu_regs`

## Requirements
- R1: An access counts only when address bits [15:13] equal 3'b001 (0x2000 to 0x3FFF), and address bits [2:0] alone pick the register: 0 control, 1 mask, 2 status, 3 sprite address, 4 sprite data, 5 scroll, 6 pointer address, 7 pointer data. An access outside the window changes nothing and reads 0.
- R2: Control bits [1:0] set `nt_base` to 0x2000, 0x2400, 0x2800 or 0x2C00 for 00, 01, 10 and 11.
- R3: Control bit 4 sets `bg_pat_base` and bit 3 sets `spr_pat_base`, each 0x1000 when the bit is set and 0x0000 when clear. Bit 5 drives `spr_tall` (8x16 sprites). Bit 6 affects no output.
- R4: The vertical-blank flag is set by `vblank_start`. It is cleared by `vblank_end` or by a status read. When a set and a status read fall in the same cycle, the read returns the old flag and the set wins.
- R5: `irq_n` is low exactly while the flag and control bit 7 are both 1. If bit 7 is written to 1 during an active blank, `irq_n` falls in the following cycle.
- R6: A status read returns the flag on bit 7, `spr0_hit` on bit 6, `spr_ovf` on bit 5, and 0 on bits [4:0].
- R7: Scroll and address ports share one write phase. On the address port, the first write loads pointer bits [13:8] from data bits [5:0] and the second write loads bits [7:0] and commits the pointer. On the scroll port, the first write sets `scroll_x` and the second sets `scroll_y`. A status read returns the phase to first.
- R8: Each data-port access presents the pointer on `vram_addr` with `vram_we` (write) or `vram_re` (read). A read returns `vram_rdata`. After the access the pointer advances by 1 when control bit 2 is 0 and by 32 when it is 1, wrapping modulo 2^14.
- R9: A write to the sprite-address port loads `oam_addr`. A write to the sprite-data port pulses `oam_we` at the current address and then increments `oam_addr` modulo 256. A read of the sprite-data port returns `oam_rdata` and leaves the address alone.
- R10: After reset, control, mask, scroll, sprite address, pointer and the flag are 0, the phase is first and `irq_n` is high.
- R11: Reads of control, mask, sprite address, scroll and pointer address return 0. `mask_out` shows the last byte written to the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid in the strobe cycle |
| vblank_start | input | 1 | Pulse at start of vertical blank |
| vblank_end | input | 1 | Pulse at end of vertical blank |
| spr0_hit | input | 1 | Sprite-0 hit level |
| spr_ovf | input | 1 | Sprite overflow level |
| irq_n | output | 1 | Active-low vertical-blank interrupt |
| nt_base | output | 14 | Base nametable address |
| bg_pat_base | output | 14 | Background pattern table base |
| spr_pat_base | output | 14 | 8x8 sprite pattern table base |
| spr_tall | output | 1 | 1 for 8x16 sprites |
| mask_out | output | 8 | Mask register contents |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_addr | output | 14 | Video-memory pointer |
| vram_wdata | output | 8 | Video-memory write data |
| vram_we | output | 1 | Video-memory write strobe |
| vram_re | output | 1 | Video-memory read strobe |
| vram_rdata | input | 8 | Video-memory read data |
| oam_addr | output | 8 | Sprite-memory address |
| oam_wdata | output | 8 | Sprite-memory write data |
| oam_we | output | 1 | Sprite-memory write strobe |
| oam_rdata | input | 8 | Sprite-memory read data |

## Verification
The hardest case to reach from the ports is a status read that lands in the very cycle in which `vblank_start` arrives. The bench raises the read strobe and the start pulse on the same falling edge. It then checks two things: the read returns the old flag, and a later read sees the flag set.

A second case is the shared write phase left half-way. The bench interleaves scroll and address writes and inserts status reads between them. It then checks which byte landed where.

Pointer wrap at the top of the 14-bit space is checked at both step sizes.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_MASK   = 3'd1,
        REG_STAT   = 3'd2,
        REG_SADDR  = 3'd3,
        REG_SDATA  = 3'd4,
        REG_SCROLL = 3'd5,
        REG_VADDR  = 3'd6,
        REG_VDATA  = 3'd7
    } reg_idx_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic       irq_en;
        logic       spr_tall;
        logic       bg_hi;
        logic       spr_hi;
        logic       step32;
        logic [1:0] nt_sel;
    } ctrl_t;

endpackage

// File: rtl/vreg_decode.sv
module vreg_decode #(
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 3,
    parameter int WIN_LSB = 13,
    parameter int WIN_TAG = 1
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    rd,
    input  logic                    wr,
    output logic                    hit,
    output logic [(1<<SEL_W)-1:0]   rd_sel,
    output logic [(1<<SEL_W)-1:0]   wr_sel
);
    localparam int NREG  = 1 << SEL_W;
    localparam int TAG_W = ADDR_W - WIN_LSB;

    assign hit = (addr[ADDR_W-1:WIN_LSB] == TAG_W'(WIN_TAG));

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign rd_sel[i] = rd && hit && (addr[SEL_W-1:0] == SEL_W'(i));
        assign wr_sel[i] = wr && hit && (addr[SEL_W-1:0] == SEL_W'(i));
    end
endmodule

// File: rtl/vreg_phase_fsm.sv
module vreg_phase_fsm
    import vreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clear,
    output logic is_first
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = PH_FIRST;
        end else if (adv) begin
            unique case (state_q)
                PH_FIRST:  state_d = PH_SECOND;
                PH_SECOND: state_d = PH_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        is_first = (state_q == PH_FIRST);
    end

    assert_status_clears_phase_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == PH_FIRST));

    assert_write_flips_phase_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (adv && !clear) |=> (state_q != $past(state_q)));
endmodule

// File: rtl/vreg_vram_ptr.sv
module vreg_vram_ptr #(
    parameter int PTR_W  = 14,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bump,
    input  logic              step32,
    output logic [PTR_W-1:0]  ptr
);
    localparam int HI_W = PTR_W - DATA_W;
    localparam logic [PTR_W-1:0] STEP_ACROSS = PTR_W'(1);
    localparam logic [PTR_W-1:0] STEP_DOWN   = PTR_W'(ROW_W);

    logic [HI_W-1:0]  hi_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] step;

    assign step = step32 ? STEP_DOWN : STEP_ACROSS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (ld_hi) begin
            hi_q <= wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_lo) begin
            ptr_q <= {hi_q, wdata};
        end else if (bump) begin
            ptr_q <= ptr_q + step;
        end
    end

    assign ptr = ptr_q;

    assert_ptr_step_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bump && !ld_lo) |=> ((ptr_q - $past(ptr_q)) ==
                              ($past(step32) ? PTR_W'(ROW_W) : PTR_W'(1))));

    assert_ptr_commit_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        ld_lo |=> (ptr_q[DATA_W-1:0] == $past(wdata)));
endmodule

// File: rtl/vreg_vblank.sv
module vreg_vblank (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic end_pulse,
    input  logic stat_rd,
    input  logic irq_en,
    output logic flag,
    output logic irq_n
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (set_pulse)            flag_q <= 1'b1;
        else if (end_pulse || stat_rd) flag_q <= 1'b0;
    end

    assign flag  = flag_q;
    assign irq_n = !(flag_q && irq_en);

    assert_set_wins_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        set_pulse |=> flag_q);

    assert_read_clears_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_pulse) |=> !flag_q);
endmodule

// File: rtl/vid_cpu_regs.sv
module vid_cpu_regs
    import vreg_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int PTR_W   = 14,
    parameter int OAM_W   = 8,
    parameter int SEL_W   = 3,
    parameter int ROW_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              vblank_start,
    input  logic              vblank_end,
    input  logic              spr0_hit,
    input  logic              spr_ovf,
    output logic              irq_n,
    output logic [PTR_W-1:0]  nt_base,
    output logic [PTR_W-1:0]  bg_pat_base,
    output logic [PTR_W-1:0]  spr_pat_base,
    output logic              spr_tall,
    output logic [DATA_W-1:0] mask_out,
    output logic [DATA_W-1:0] scroll_x,
    output logic [DATA_W-1:0] scroll_y,
    output logic [PTR_W-1:0]  vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    output logic              vram_we,
    output logic              vram_re,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic [OAM_W-1:0]  oam_addr,
    output logic [DATA_W-1:0] oam_wdata,
    output logic              oam_we,
    input  logic [DATA_W-1:0] oam_rdata
);
    localparam int NREG     = 1 << SEL_W;
    localparam int NT_SHIFT = 10;
    localparam logic [PTR_W-1:0] NT_ORIGIN = PTR_W'(14'h2000);
    localparam logic [PTR_W-1:0] PAT_HIGH  = PTR_W'(14'h1000);
    localparam int STAT_PAD = DATA_W - 3;

    logic [NREG-1:0]   rd_sel, wr_sel;
    logic              in_win;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] mask_q, sx_q, sy_q;
    logic [OAM_W-1:0]  oam_q;
    logic              ph_first;
    logic              vbl_flag;
    logic [PTR_W-1:0]  ptr;

    vreg_decode #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W),
        .WIN_LSB(13),
        .WIN_TAG(1)
    ) u_dec (
        .addr  (cpu_addr),
        .rd    (cpu_rd),
        .wr    (cpu_wr),
        .hit   (in_win),
        .rd_sel(rd_sel),
        .wr_sel(wr_sel)
    );

    vreg_phase_fsm u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (wr_sel[REG_SCROLL] || wr_sel[REG_VADDR]),
        .clear   (rd_sel[REG_STAT]),
        .is_first(ph_first)
    );

    vreg_vram_ptr #(
        .PTR_W (PTR_W),
        .DATA_W(DATA_W),
        .ROW_W (ROW_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (wr_sel[REG_VADDR] && ph_first),
        .ld_lo (wr_sel[REG_VADDR] && !ph_first),
        .wdata (cpu_wdata),
        .bump  (wr_sel[REG_VDATA] || rd_sel[REG_VDATA]),
        .step32(ctrl_q.step32),
        .ptr   (ptr)
    );

    vreg_vblank u_vbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pulse(vblank_start),
        .end_pulse(vblank_end),
        .stat_rd  (rd_sel[REG_STAT]),
        .irq_en   (ctrl_q.irq_en),
        .flag     (vbl_flag),
        .irq_n    (irq_n)
    );

    // Control: bit 6 is not stored, it has no function.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_sel[REG_CTRL]) begin
            ctrl_q.irq_en   <= cpu_wdata[7];
            ctrl_q.spr_tall <= cpu_wdata[5];
            ctrl_q.bg_hi    <= cpu_wdata[4];
            ctrl_q.spr_hi   <= cpu_wdata[3];
            ctrl_q.step32   <= cpu_wdata[2];
            ctrl_q.nt_sel   <= cpu_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                mask_q <= '0;
        else if (wr_sel[REG_MASK]) mask_q <= cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sx_q <= '0;
            sy_q <= '0;
        end else if (wr_sel[REG_SCROLL]) begin
            if (ph_first) sx_q <= cpu_wdata;
            else          sy_q <= cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 oam_q <= '0;
        else if (wr_sel[REG_SADDR]) oam_q <= cpu_wdata[OAM_W-1:0];
        else if (wr_sel[REG_SDATA]) oam_q <= oam_q + OAM_W'(1);
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd && in_win) begin
            unique case (reg_idx_e'(cpu_addr[SEL_W-1:0]))
                REG_STAT:  cpu_rdata = {vbl_flag, spr0_hit, spr_ovf, {STAT_PAD{1'b0}}};
                REG_SDATA: cpu_rdata = oam_rdata;
                REG_VDATA: cpu_rdata = vram_rdata;
                default:   cpu_rdata = '0;
            endcase
        end
    end

    assign nt_base      = NT_ORIGIN + (PTR_W'(ctrl_q.nt_sel) << NT_SHIFT);
    assign bg_pat_base  = ctrl_q.bg_hi  ? PAT_HIGH : '0;
    assign spr_pat_base = ctrl_q.spr_hi ? PAT_HIGH : '0;
    assign spr_tall     = ctrl_q.spr_tall;
    assign mask_out     = mask_q;
    assign scroll_x     = sx_q;
    assign scroll_y     = sy_q;
    assign vram_addr    = ptr;
    assign vram_wdata   = cpu_wdata;
    assign vram_we      = wr_sel[REG_VDATA];
    assign vram_re      = rd_sel[REG_VDATA];
    assign oam_addr     = oam_q;
    assign oam_wdata    = cpu_wdata;
    assign oam_we       = wr_sel[REG_SDATA];

    assert_outside_ignored_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cpu_wr && !in_win) |=> ($stable(ctrl_q) && $stable(mask_q) && $stable(ptr)));

    assert_enable_in_blank_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_sel[REG_CTRL] && cpu_wdata[7] && vbl_flag && !vblank_end && !rd_sel[REG_STAT])
        |=> !irq_n);

    assert_oam_increment_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        oam_we |=> (oam_addr == $past(oam_addr) + OAM_W'(1)));
endmodule

// File: tb/tb_vid_cpu_regs.sv
module tb_vid_cpu_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        vblank_start = 1'b0, vblank_end = 1'b0;
    logic        spr0_hit = 1'b0, spr_ovf = 1'b0;
    logic        irq_n;
    logic [13:0] nt_base, bg_pat_base, spr_pat_base, vram_addr;
    logic        spr_tall, vram_we, vram_re, oam_we;
    logic [7:0]  mask_out, scroll_x, scroll_y, vram_wdata, oam_addr, oam_wdata;
    logic [7:0]  vram_rdata = 8'h5A;
    logic [7:0]  oam_rdata = 8'hC3;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic        snap_vwe, snap_vre, snap_owe;
    logic [13:0] snap_vaddr;
    logic [7:0]  snap_oaddr;
    logic [7:0]  rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_cpu_regs dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .vblank_start(vblank_start), .vblank_end(vblank_end),
        .spr0_hit(spr0_hit), .spr_ovf(spr_ovf), .irq_n(irq_n),
        .nt_base(nt_base), .bg_pat_base(bg_pat_base), .spr_pat_base(spr_pat_base),
        .spr_tall(spr_tall), .mask_out(mask_out), .scroll_x(scroll_x),
        .scroll_y(scroll_y), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .vram_we(vram_we), .vram_re(vram_re), .vram_rdata(vram_rdata),
        .oam_addr(oam_addr), .oam_wdata(oam_wdata), .oam_we(oam_we),
        .oam_rdata(oam_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        snap_vwe = vram_we; snap_vaddr = vram_addr;
        snap_owe = oam_we;  snap_oaddr = oam_addr;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        rd_val = cpu_rdata; snap_vre = vram_re; snap_vaddr = vram_addr;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); vblank_start = 1'b1;
        @(negedge clk); vblank_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); vblank_end = 1'b1;
        @(negedge clk); vblank_end = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R10 irq_n", irq_n, 1);
        chk("R10 nt_base", nt_base, 14'h2000);
        chk("R10 vram_addr", vram_addr, 0);
        chk("R10 oam_addr", oam_addr, 0);
        chk("R10 mask", mask_out, 0);
        chk("R10 scroll", {scroll_x, scroll_y}, 0);
        bus_rd(16'h2002);
        chk("R10 status", rd_val, 8'h00);
    endtask

    task automatic t_ctrl();
        for (int n = 0; n < 4; n++) begin
            bus_wr(16'h2000, 8'(n));
            chk("R2 nt_base", nt_base, 32'h2000 + n * 32'h400);
        end
        bus_wr(16'h3FF8, 8'h38);
        chk("R1 R3 bg base via mirror", bg_pat_base, 14'h1000);
        chk("R3 spr base", spr_pat_base, 14'h1000);
        chk("R3 spr_tall", spr_tall, 1);
        chk("R2 nt back to 0", nt_base, 14'h2000);
        bus_wr(16'h2000, 8'h40);
        chk("R3 bit6 no effect", {bg_pat_base, spr_pat_base, spr_tall, nt_base, irq_n},
            {14'h0, 14'h0, 1'b0, 14'h2000, 1'b1});
        bus_wr(16'h4000, 8'h03);
        chk("R1 above window ignored", nt_base, 14'h2000);
        bus_wr(16'h1FF8, 8'h02);
        chk("R1 below window ignored", nt_base, 14'h2000);
    endtask

    task automatic t_ptr();
        bus_wr(16'h2000, 8'h00);
        bus_wr(16'h3456, 8'h21);
        bus_wr(16'h2006, 8'h08);
        chk("R7 R1 pointer load", vram_addr, 14'h2108);
        bus_wr(16'h2007, 8'h77);
        chk("R8 write strobe", snap_vwe, 1);
        chk("R8 write addr", snap_vaddr, 14'h2108);
        chk("R8 step 1", vram_addr, 14'h2109);
        bus_wr(16'h2000, 8'h04);
        bus_rd(16'h2007);
        chk("R8 read data", rd_val, 8'h5A);
        chk("R8 read strobe", snap_vre, 1);
        chk("R8 step 32", vram_addr, 14'h2129);
        bus_wr(16'h2006, 8'hFF);
        bus_wr(16'h2006, 8'hF0);
        chk("R7 high bits masked", vram_addr, 14'h3FF0);
        bus_wr(16'h2007, 8'h00);
        chk("R8 wrap step 32", vram_addr, 14'h0010);
        bus_wr(16'h2000, 8'h00);
        bus_wr(16'h2006, 8'h3F);
        bus_wr(16'h2006, 8'hFF);
        bus_wr(16'h2007, 8'h00);
        chk("R8 wrap step 1", vram_addr, 14'h0000);
    endtask

    task automatic t_phase();
        bus_wr(16'h2006, 8'h12);
        bus_rd(16'h2002);
        bus_wr(16'h2006, 8'h05);
        bus_wr(16'h2006, 8'h00);
        chk("R7 status resets phase", vram_addr, 14'h0500);
        bus_wr(16'h2005, 8'h11);
        bus_wr(16'h2005, 8'h22);
        chk("R7 scroll pair", {scroll_x, scroll_y}, 16'h1122);
        bus_wr(16'h2005, 8'h33);
        bus_wr(16'h2006, 8'h44);
        chk("R7 shared phase ptr", vram_addr, 14'h0544);
        chk("R7 shared phase scroll", {scroll_x, scroll_y}, 16'h3322);
    endtask

    task automatic t_vblank();
        bus_wr(16'h2000, 8'h00);
        pulse_start();
        chk("R5 disabled no irq", irq_n, 1);
        bus_rd(16'h3FFA);
        chk("R4 flag read", rd_val, 8'h80);
        bus_rd(16'h2002);
        chk("R4 read cleared flag", rd_val, 8'h00);
        pulse_start();
        bus_wr(16'h2000, 8'h80);
        chk("R5 enable in blank", irq_n, 0);
        pulse_end();
        chk("R4 R5 end clears", irq_n, 1);
        pulse_start();
        chk("R5 irq at start", irq_n, 0);
        bus_rd(16'h2002);
        chk("R4 R5 read releases irq", irq_n, 1);
        @(negedge clk);
        cpu_addr = 16'h2002; cpu_rd = 1'b1; vblank_start = 1'b1;
        #1 rd_val = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; vblank_start = 1'b0;
        chk("R4 collision old value", rd_val, 8'h00);
        chk("R4 collision set wins", irq_n, 0);
        bus_rd(16'h2002);
        chk("R4 collision flag set", rd_val, 8'h80);
        bus_wr(16'h2000, 8'h00);
        spr0_hit = 1'b1;
        bus_rd(16'h2002);
        chk("R6 sprite0 bit", rd_val, 8'h40);
        spr0_hit = 1'b0; spr_ovf = 1'b1;
        bus_rd(16'h2002);
        chk("R6 overflow bit", rd_val, 8'h20);
        spr_ovf = 1'b0;
    endtask

    task automatic t_oam();
        bus_wr(16'h2003, 8'hFE);
        chk("R9 addr load", oam_addr, 8'hFE);
        bus_wr(16'h2004, 8'hAA);
        chk("R9 write strobe", snap_owe, 1);
        chk("R9 write addr", snap_oaddr, 8'hFE);
        chk("R9 increment", oam_addr, 8'hFF);
        bus_wr(16'h2004, 8'hBB);
        chk("R9 wrap", oam_addr, 8'h00);
        bus_rd(16'h2004);
        chk("R9 read data", rd_val, 8'hC3);
        chk("R9 read keeps addr", oam_addr, 8'h00);
    endtask

    task automatic t_misc();
        bus_wr(16'h2001, 8'h1E);
        chk("R11 mask out", mask_out, 8'h1E);
        bus_rd(16'h2000);
        chk("R11 ctrl reads 0", rd_val, 0);
        bus_rd(16'h2001);
        chk("R11 mask reads 0", rd_val, 0);
        bus_rd(16'h2006);
        chk("R11 addr port reads 0", rd_val, 0);
        bus_rd(16'h6007);
        chk("R1 outside read 0", rd_val, 0);
        chk("R1 outside no strobe", snap_vre, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_ptr();
        t_phase();
        t_vblank();
        t_oam();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule